// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a small memory-mapped window of 64-bit host registers. Through it a host reaches a separate space of 32-bit registers one word at a time. The host does not address the inner space directly. It stages a write value, or asks for a read, by writing a command word that holds a word index and one request bit.

The bridge then runs that one access on a downstream request/acknowledge port whose latency is not fixed. The request bit stays readable as 1 until the acknowledge arrives, so software polls the command word to learn when the access is finished. Read results land in a read-data register, next to a status flag returned by the downstream side.

A constant, read-only capability word describes the serial port that sits behind the bridge: shift order, transfer width, chip-select count, clock polarity and phase, and a peripheral identifier. All of these are set by parameters.

Top module: `regwin_bridge`

## Requirements
- R1: After reset the command word reads 0 (both request bits clear), the read-data register reads 0, and `d_req` is low.
- R2: Offset 0x08 returns a constant capability word. Bit 1 is the shift order (1 means LSB first). Bits 7:2 are the transfer width, bits 13:8 the chip-select count, bit 14 the clock polarity, bit 15 the clock phase and bits 47:32 the peripheral identifier. All other bits are 0.
- R3: A write to offset 0x20 stages a 32-bit value, which reads back in bits 31:0 of 0x20. Writing the command word (offset 0x10) with bit 8 set and the index in bits 7:0 starts a downstream write of the staged value to that index. Bit 8 reads 1 until the access is acknowledged and 0 afterwards.
- R4: Writing the command word with bit 9 set starts a downstream read. On the acknowledge, bits 31:0 of offset 0x18 take `d_rdata` and bit 32 takes `d_flag`. Bit 9 reads 1 until then. The read-data register changes on no other event.
- R5: `d_req` rises in the cycle after the command word is accepted. It then stays high, with `d_we`, `d_addr` and `d_wdata` stable, until the first cycle in which `d_ack` is sampled high, and it is low in the next cycle. An acknowledge in the first request cycle is legal.
- R6: A command written while an access is pending is ignored. Restaging write data during an access does not alter the `d_wdata` of the access in flight, and no downstream request starts without a command write.
- R7: A command with both bits 8 and 9 set starts no access and leaves both bits clear.
- R8: A command whose index field (bits 7:0) exceeds the highest word index, which is 6 for a highest byte address of 24, starts no access and leaves both bits clear. A downstream address never exceeds that index.
- R9: Host writes to offsets 0x08 and 0x18 have no effect. Reads of any offset other than 0x08, 0x10, 0x18 and 0x20 return 0, and writes to them have no effect.
- R10: When idle, the command word reads back the index of the last accepted command in its low bits, with bits 9:8 clear and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | AW (8) | Host byte offset |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data for `h_addr` (combinational) |
| d_req | output | 1 | Downstream access request |
| d_we | output | 1 | Downstream write enable (1 = write) |
| d_addr | output | IDX_W (3) | Downstream word index |
| d_wdata | output | 32 | Downstream write data |
| d_ack | input | 1 | Downstream acknowledge |
| d_rdata | input | 32 | Downstream read data, valid with `d_ack` |
| d_flag | input | 1 | Downstream status flag, valid with `d_ack` |

## Verification
The assertions assume that the downstream side raises `d_ack` only while `d_req` is high, and only for one cycle per request. They also assume that `d_rdata` and `d_flag` are meaningful only in the acknowledge cycle. The bench responder models this. It counts the latency from the first cycle in which it sees a request, pulses the acknowledge once, and drops it on the next falling edge. Latencies of zero up to fifteen cycles are used, so that commands issued during an access fall inside a real pending window.

// File: rtl/regwin_bridge.sv
module regwin_bridge #(
  parameter int AW = 8,
  parameter int MAX_BYTE = 24,
  parameter int SHIFT_LSB = 0,
  parameter int XFER_BITS = 32,
  parameter int CS_COUNT = 1,
  parameter int CLK_POL = 0,
  parameter int CLK_PHA = 0,
  parameter logic [15:0] PERIPH_ID = 16'h0001,
  localparam int MAX_IDX = MAX_BYTE / 4,
  localparam int IDX_W = $clog2(MAX_IDX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_wr,
  input  logic [AW-1:0]    h_addr,
  input  logic [63:0]      h_wdata,
  output logic [63:0]      h_rdata,
  output logic             d_req,
  output logic             d_we,
  output logic [IDX_W-1:0] d_addr,
  output logic [31:0]      d_wdata,
  input  logic             d_ack,
  input  logic [31:0]      d_rdata,
  input  logic             d_flag
);
  localparam logic [AW-1:0] OFF_CAP = AW'(8);
  localparam logic [AW-1:0] OFF_CMD = AW'(16);
  localparam logic [AW-1:0] OFF_RDD = AW'(24);
  localparam logic [AW-1:0] OFF_WRD = AW'(32);

  localparam logic [63:0] CAP_WORD = {16'h0, PERIPH_ID, 16'h0,
                                      1'(CLK_PHA), 1'(CLK_POL), 6'(CS_COUNT),
                                      6'(XFER_BITS), 1'(SHIFT_LSB), 1'b0};

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      stage_q;
  logic [31:0]      fly_q;
  logic [32:0]      rd_q;

  wire cmd_wr  = h_wr && (h_addr == OFF_CMD);
  wire want_wr = h_wdata[8];
  wire want_rd = h_wdata[9];
  wire idx_ok  = h_wdata[7:0] <= 8'(MAX_IDX);
  wire accept  = cmd_wr && (st == S_IDLE);
  wire launch  = accept && idx_ok && (want_wr ^ want_rd);
  wire done    = (st != S_IDLE) && d_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx_q   <= '0;
      stage_q <= '0;
      fly_q   <= '0;
      rd_q    <= '0;
    end else begin
      if (h_wr && (h_addr == OFF_WRD))
        stage_q <= h_wdata[31:0];
      if (accept && idx_ok)
        idx_q <= h_wdata[IDX_W-1:0];
      if (launch) begin
        st    <= want_wr ? S_WR : S_RD;
        fly_q <= stage_q;
      end else if (done) begin
        st <= S_IDLE;
        if (st == S_RD)
          rd_q <= {d_flag, d_rdata};
      end
    end
  end

  assign d_req   = (st != S_IDLE);
  assign d_we    = (st == S_WR);
  assign d_addr  = idx_q;
  assign d_wdata = fly_q;

  always_comb begin
    case (h_addr)
      OFF_CAP: h_rdata = CAP_WORD;
      OFF_CMD: h_rdata = {54'h0, st == S_RD, st == S_WR, 8'(idx_q)};
      OFF_RDD: h_rdata = {31'h0, rd_q};
      OFF_WRD: h_rdata = {32'h0, stage_q};
      default: h_rdata = '0;
    endcase
  end
endmodule

module regwin_bridge_chk #(
  parameter int AW = 8,
  parameter int IDX_W = 3,
  parameter int MAX_IDX = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             h_wr,
  input logic [AW-1:0]    h_addr,
  input logic             d_req,
  input logic             d_we,
  input logic [IDX_W-1:0] d_addr,
  input logic [31:0]      d_wdata,
  input logic             d_ack,
  input logic [32:0]      rd_q
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    d_req && !d_ack |=> d_req && $stable(d_addr) && $stable(d_we) && $stable(d_wdata));

  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    d_req && d_ack |=> !d_req);

  assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_req) |-> $past(h_wr && h_addr == AW'(16)));

  assert_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> d_addr <= IDX_W'(MAX_IDX));

  assert_rdhold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_req && d_ack && !d_we) |=> $stable(rd_q));
endmodule

bind regwin_bridge regwin_bridge_chk #(.AW(AW), .IDX_W(IDX_W), .MAX_IDX(MAX_IDX)) i_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .d_req(d_req),
  .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_ack(d_ack), .rd_q(rd_q));

// File: tb/test_regwin_bridge.sv
module test_regwin_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] CAP_EXP = {16'h0, 16'hA5C3, 16'h0, 1'b0, 1'b1, 6'd3, 6'd8, 1'b1, 1'b0};

  logic        clk = 0, rst_n = 0, h_wr = 0;
  logic [7:0]  h_addr = 0;
  logic [63:0] h_wdata = 0, h_rdata;
  logic        d_req, d_we, d_ack = 0, d_flag = 0;
  logic [2:0]  d_addr;
  logic [31:0] d_wdata, d_rdata = 0;

  int checks = 0, fails = 0, reqs = 0, lat = 0;
  bit finished = 0;
  logic [35:0] expq[$];
  logic [31:0] mem [8];

  regwin_bridge #(.SHIFT_LSB(1), .XFER_BITS(8), .CS_COUNT(3), .CLK_POL(1), .CLK_PHA(0),
                  .PERIPH_ID(16'hA5C3)) i_regwin_bridge (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_ack(d_ack), .d_rdata(d_rdata), .d_flag(d_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [7:0] a, logic [63:0] v);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = v;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic hread(logic [7:0] a, output logic [63:0] v);
    h_addr = a; #1; v = h_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [63:0] v;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); hread(8'h10, v);
      if (v[9:8] == 2'b00) return;
    end
    chk(req, v[9:8], 0);
  endtask

  // Monitor/responder: pops expected accesses and acknowledges after lat cycles.
  initial begin
    bit busy = 0;
    int cnt = 0;
    logic [35:0] e;
    for (int i = 0; i < 8; i++) mem[i] = 32'h1000_0000 + i;
    forever begin
      @(negedge clk);
      d_ack = 0;
      if (d_req && !busy) begin
        busy = 1; cnt = 0; reqs++;
        if (expq.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6: unexpected request actual we=%0d addr=%0d expected none", d_we, d_addr);
        end else begin
          e = expq.pop_front();
          chk("R3/R4 access kind and index", {d_we, d_addr}, {e[35], e[34:32]});
          if (d_we) chk("R3/R6 write data", d_wdata, e[31:0]);
        end
      end
      if (busy) begin
        if (cnt == lat) begin
          d_ack = 1; d_flag = d_addr[0]; d_rdata = mem[d_addr];
          if (d_we) mem[d_addr] = d_wdata;
          busy = 0;
        end else cnt++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int n;
    repeat (3) @(negedge clk);
    hread(8'h10, v); chk("R1 command after reset", v, 0);
    hread(8'h18, v); chk("R1 read data after reset", v, 0);
    chk("R1 d_req after reset", d_req, 0);
    @(negedge clk); rst_n = 1;

    hread(8'h08, v); chk("R2 capability", v, CAP_EXP);
    hwrite(8'h08, '1);
    hread(8'h08, v); chk("R9 capability write ignored", v, CAP_EXP);

    lat = 3;
    hwrite(8'h20, 64'hFFFF_FFFF_DEAD_BEEF);
    hread(8'h20, v); chk("R3 staged readback", v, 64'hDEAD_BEEF);
    expq.push_back({1'b1, 3'd2, 32'hDEAD_BEEF});
    hwrite(8'h10, 64'h102);
    hread(8'h10, v); chk("R3 write pending", v, 64'h102);
    wait_idle("R3 write completes");
    hread(8'h10, v); chk("R10 idle readback", v, 64'h2);

    lat = 5;
    expq.push_back({1'b0, 3'd2, 32'h0});
    hwrite(8'h10, 64'h202);
    hread(8'h10, v); chk("R4 read pending", v, 64'h202);
    wait_idle("R4 read completes");
    hread(8'h18, v); chk("R4 read data", v, {31'h0, 1'b0, 32'hDEAD_BEEF});

    lat = 0;
    expq.push_back({1'b0, 3'd5, 32'h0});
    hwrite(8'h10, 64'h205);
    wait_idle("R5 zero latency");
    hread(8'h18, v); chk("R4/R5 flag and data", v, {31'h0, 1'b1, 32'h1000_0005});

    lat = 15; n = reqs;
    hwrite(8'h20, 64'hAAAA_0001);
    expq.push_back({1'b1, 3'd1, 32'hAAAA_0001});
    hwrite(8'h10, 64'h101);
    hwrite(8'h20, 64'h5555_0002);
    hwrite(8'h10, 64'h203);
    hread(8'h10, v); chk("R6 command ignored while pending", v, 64'h101);
    wait_idle("R6 completes");
    repeat (4) @(negedge clk);
    chk("R6 one request only", reqs, n + 1);
    hread(8'h20, v); chk("R6 restaged value kept", v, 64'h5555_0002);
    lat = 2;
    expq.push_back({1'b0, 3'd1, 32'h0});
    hwrite(8'h10, 64'h201);
    wait_idle("R6 readback");
    hread(8'h18, v); chk("R6 in-flight data unchanged", v, {31'h0, 1'b1, 32'hAAAA_0001});

    n = reqs;
    hwrite(8'h10, 64'h304);
    hread(8'h10, v); chk("R7 both bits clear", v[9:8], 0);
    repeat (8) @(negedge clk);
    chk("R7 no access", reqs, n);

    hwrite(8'h10, 64'h107);
    hread(8'h10, v); chk("R8 out of range bits clear", v[9:8], 0);
    repeat (8) @(negedge clk);
    chk("R8 no access", reqs, n);

    hwrite(8'h18, '1);
    hread(8'h18, v); chk("R9 read data write ignored", v, {31'h0, 1'b1, 32'hAAAA_0001});
    hwrite(8'h00, '1);
    hread(8'h00, v); chk("R9 unmapped 0x00", v, 0);
    hread(8'h28, v); chk("R9 unmapped 0x28", v, 0);
    hread(8'h11, v); chk("R9 unaligned 0x11", v, 0);
    chk("R3 queue drained", expq.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule